// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers 32 interrupt inputs and combines them onto one active-low request line to a processor. Each input has its own control register that sets its trigger type (low level, high level, falling edge, rising edge) and a 3-bit priority. Inputs are enabled and disabled through two write-one command registers. Each input is synchronised and then turned into a pending bit. A combinational arbiter picks one winner among the pending, enabled inputs.

Software services an interrupt in three steps. It reads the encoding register and gets back the winning source number times four. That read acknowledges the request: the request line rises, an edge-latched pending bit for the winner is cleared, and the controller enters a service phase. While the service phase lasts, no new request is raised. A write of any value to the end-of-service register ends the phase and re-arms arbitration.

The register bus is word-addressed: `addr` carries the byte offset divided by four. A read is issued by holding `rd_en` for one cycle, and `rdata` is valid from the following cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, every source is disabled (the enable read at word 0x45 returns 0), every control register reads 0, and no service phase is in progress.
- R2: Source n has its control register at word address n (0 to 31). Bits [7:6] hold the trigger type and bits [2:0] hold the priority. A read returns only these bits, and every other bit reads 0.
- R3: Trigger type 0 makes a source pending while its synchronised input is 0. Type 1 makes it pending while the input is 1. The synchronised input levels read at word 0x40.
- R4: Writing to word 0x48 enables each source whose data bit is 1. Writing to word 0x49 disables each source whose data bit is 1. Zero bits change nothing in either case. The enable set reads at word 0x45, with bit n equal to 1 meaning source n is enabled.
- R5: Reading word 0x43 returns the winning source number times four. If a request was raised, the read also acknowledges it: `irq_n` is 1 in the cycle after the read, and a service phase starts.
- R6: During a service phase `irq_n` stays 1, even if other sources are pending. A write of any value to word 0x4C ends the phase, and a request is raised again one cycle later if any enabled source is still pending.
- R7: Priority 7 is the highest. Among sources of equal priority, the lowest-numbered source wins.
- R8: Type 3 latches a pending bit on a rising edge of the synchronised input, and type 2 latches it on a falling edge. The bit stays set after the input returns to its old level. It is cleared only when that source is acknowledged.
- R9: Word 0x41 reads the set of sources that are both pending and enabled. A disabled source never causes `irq_n` to go to 0.
- R10: `rdata` takes the addressed value on the clock edge at which `rd_en` is 1, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt inputs, one bit per source |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Word address (byte offset divided by four) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench first makes sure the request stays high during a service phase while a level source is still asserted. A design that skips this would re-enter the handler before end-of-service. It also sets up three enabled sources, two of which tie on priority, and checks that the lower-numbered one wins. It then raises one of them to priority 7 and checks that this source now wins over both. A pulsed edge source must stay pending after its input falls and must clear only on its own acknowledge; a design that handled this wrong would either lose short pulses or fire twice. The bench also checks that enable and disable writes leave zero bits alone, and that a disabled low-level source, which is pending straight out of reset, never pulls the request line low.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_i,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [6:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_n
);
  localparam int NSRC = 32;
  localparam int IDW  = $clog2(NSRC);
  localparam logic [6:0] A_RAW = 7'h40;
  localparam logic [6:0] A_ACT = 7'h41;
  localparam logic [6:0] A_ENC = 7'h43;
  localparam logic [6:0] A_EN  = 7'h45;
  localparam logic [6:0] A_SET = 7'h48;
  localparam logic [6:0] A_CLR = 7'h49;
  localparam logic [6:0] A_EOS = 7'h4C;

  logic [1:0]      typ [NSRC];
  logic [2:0]      pri [NSRC];
  logic [NSRC-1:0] sync_r [SYNC_STAGES];
  logic [NSRC-1:0] sin, prev, epend, pend, act, en;
  logic            irq_q, busy;
  logic [IDW-1:0]  win;
  logic [2:0]      win_p;
  logic            any;
  logic [31:0]     rmux;

  wire is_cfg = addr[6:5] == 2'b00;
  wire ack    = rd_en && addr == A_ENC && irq_q;
  wire eos    = wr_en && addr == A_EOS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_r[s] <= '0;
      prev <= '0;
    end else begin
      sync_r[0] <= src_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_r[s] <= sync_r[s-1];
      prev <= sync_r[SYNC_STAGES-1];
    end

  assign sin = sync_r[SYNC_STAGES-1];

  always_comb
    for (int i = 0; i < NSRC; i++)
      pend[i] = typ[i][1] ? epend[i] : (typ[i][0] ? sin[i] : ~sin[i]);

  assign act = pend & en;
  assign any = |act;

  always_comb begin
    win   = '0;
    win_p = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (act[i] && (pri[i] >= win_p || win_p == 3'd0 && !act[win])) begin
        win   = IDW'(i);
        win_p = pri[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        typ[i] <= '0;
        pri[i] <= '0;
      end
      en    <= '0;
      epend <= '0;
    end else begin
      if (wr_en && is_cfg) begin
        typ[addr[4:0]] <= wdata[7:6];
        pri[addr[4:0]] <= wdata[2:0];
      end
      if (wr_en && addr == A_SET) en <= en | wdata;
      if (wr_en && addr == A_CLR) en <= en & ~wdata;
      for (int i = 0; i < NSRC; i++) begin
        if (ack && win == IDW'(i)) epend[i] <= 1'b0;
        if (typ[i] == 2'd3 && sin[i] && !prev[i]) epend[i] <= 1'b1;
        if (typ[i] == 2'd2 && !sin[i] && prev[i]) epend[i] <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_q <= 1'b0;
      busy  <= 1'b0;
    end else if (ack) begin
      irq_q <= 1'b0;
      busy  <= 1'b1;
    end else if (eos) begin
      irq_q <= 1'b0;
      busy  <= 1'b0;
    end else begin
      irq_q <= !busy && any;
    end

  assign irq_n = ~irq_q;

  always_comb begin
    rmux = '0;
    if (is_cfg) rmux = {24'd0, typ[addr[4:0]], 3'd0, pri[addr[4:0]]};
    else case (addr)
      A_RAW:   rmux = sin;
      A_ACT:   rmux = act;
      A_ENC:   rmux = {25'd0, win, 2'b00};
      A_EN:    rmux = en;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rmux;

  p_ack_deasserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> irq_n && busy);
  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_n);
  p_eos_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !ack) |=> !busy);
  p_disable_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> (en & $past(wdata)) == '0);
  p_enable_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> (en & $past(wdata)) == $past(wdata));
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(any));
  p_winner_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> act[win]);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  prio_irq_ctrl i_prio_irq_ctrl (.clk(clk), .rst_n(rst_n), .src_i(src_i), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_n", irq_n, 1);
    rd(7'h45, d); chk("R1 enable", d, 0);
    rd(7'h05, d); chk("R1 cfg", d, 0);
    cyc(4);
    rd(7'h41, d); chk("R9 active masked", d, 0);
    chk("R9 irq_n masked", irq_n, 1);
    rd(7'h40, d); chk("R3 raw", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(7'h03, 32'hC5); rd(7'h03, d); chk("R2 cfg3", d, 32'hC5);
    wr(7'h1F, 32'hFFFF_FFFF); rd(7'h1F, d); chk("R2 cfg31 bits", d, 32'hC7);
    wr(7'h1F, 0); rd(7'h10, d); chk("R10 hold/cfg16", d, 0);
    chk("R10 rdata held", rdata, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(7'h48, 32'hF0); rd(7'h45, d); chk("R4 set", d, 32'hF0);
    wr(7'h48, 32'h1);  rd(7'h45, d); chk("R4 set keeps", d, 32'hF1);
    wr(7'h49, 32'h30); rd(7'h45, d); chk("R4 clr", d, 32'hC1);
    wr(7'h49, 32'hFFFF_FFFF); rd(7'h45, d); chk("R4 clr all", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(7'h04, 32'h43); wr(7'h48, 32'h10);
    src_i[4] = 1; cyc(5);
    chk("R3 high level irq", irq_n, 0);
    rd(7'h40, d); chk("R3 raw bit4", d, 32'h10);
    rd(7'h41, d); chk("R9 active", d, 32'h10);
    rd(7'h43, d); chk("R5 enc", d, 16);
    chk("R5 irq released", irq_n, 1);
    cyc(5); chk("R6 quiet in service", irq_n, 1);
    wr(7'h4C, 0); cyc(3); chk("R6 rearm", irq_n, 0);
    src_i[4] = 0; cyc(5); chk("R3 level drop", irq_n, 1);
    wr(7'h04, 32'h03); cyc(3); chk("R3 low level irq", irq_n, 0);
    wr(7'h49, 32'hFFFF_FFFF); wr(7'h04, 32'h43); cyc(3);
    chk("R9 disabled quiet", irq_n, 1);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(7'h02, 32'h45); wr(7'h09, 32'h45); wr(7'h14, 32'h42);
    src_i[2] = 1; src_i[9] = 1; src_i[20] = 1;
    wr(7'h48, 32'h0010_0204); cyc(5);
    rd(7'h43, d); chk("R7 tie lowest", d, 8);
    wr(7'h4C, 0); wr(7'h14, 32'h47); cyc(3);
    rd(7'h43, d); chk("R7 prio7 wins", d, 80);
    wr(7'h4C, 0);
    wr(7'h49, 32'hFFFF_FFFF);
    src_i[2] = 0; src_i[9] = 0; src_i[20] = 0; cyc(4);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    src_i[8] = 1;
    wr(7'h07, 32'hC6); wr(7'h08, 32'h86); cyc(4);
    wr(7'h48, 32'h180); cyc(3);
    chk("R8 no edge yet", irq_n, 1);
    src_i[7] = 1; cyc(3); src_i[7] = 0; cyc(5);
    chk("R8 rising latched", irq_n, 0);
    rd(7'h41, d); chk("R8 pending held", d, 32'h80);
    rd(7'h43, d); chk("R8 enc rise", d, 28);
    rd(7'h41, d); chk("R8 cleared on ack", d, 0);
    wr(7'h4C, 0); cyc(3); chk("R8 no refire", irq_n, 1);
    src_i[8] = 0; cyc(5);
    chk("R8 falling latched", irq_n, 0);
    rd(7'h43, d); chk("R8 enc fall", d, 32);
    wr(7'h4C, 0); cyc(3); chk("R8 fall done", irq_n, 1);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_cfg();
    t_mask();
    t_level();
    t_prio();
    t_edge();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule